// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block turns the system clock into timing strobes for an asynchronous serial port. Each of the two directions, transmit and receive, gets its own pair of strobes. One pulses at sixteen times the bit rate, for oversampling. The other pulses once per bit. Every strobe is high for a single clock cycle, and the block creates no derived clocks.

The rate comes from a chain of divides:
- a coarse prescale value, chosen from a small encoded set and shared by both directions;
- a power-of-two divide, selected separately for each direction;
- an optional 8-bit fine divide for each direction, bypassed when it is zero;
- a fixed divide by sixteen, from the oversample rate down to the bit rate.

For each direction, the bit period in clock cycles is 16 × coarse × 2^select × fine, where a fine value of zero counts as one.

While a direction is enabled, its rate settings are frozen. Each direction keeps a private copy of the settings, captured while it is disabled. Disabling a direction clears its counters, so the first bit period after it is enabled again is exact. With an 8 MHz clock, coarse 13, select 0 and fine 0, the bit period is 208 cycles, which is the standard 38400-baud setting.

Top module: `baud_gen`

## Requirements
- R1: During reset and in the cycle after a reset clock edge, all four tick outputs are low.
- R2: The coarse prescale encoding `pr_sel` maps 2'b00, 2'b01, 2'b10 and 2'b11 to divide values 1, 3, 4 and 13.
- R3: A 3-bit power select of value s divides by 2^s, covering 1 to 128.
- R4: A nonzero fine value f (1 to 255) divides the oversample tick period further. That period is coarse × 2^s × f cycles.
- R5: A fine value of 0 bypasses fine division and gives the same period as f = 1.
- R6: The bit tick period is exactly 16 oversample tick periods. Every bit tick coincides with an oversample tick, and 16 oversample ticks fall between successive bit ticks.
- R7: A bit tick is never high in two consecutive cycles.
- R8: A direction whose enable was low at the previous clock edge emits no ticks.
- R9: The settings a direction uses are those present at the last clock edge at which its enable was low. Setting changes while the direction is enabled have no effect until it is disabled and enabled again.
- R10: After a direction's enable is first seen high at a clock edge, its first bit tick appears in the cycle after the 16·N-th such edge, where N is its oversample period.
- R11: The two directions run independently, each at its own configured rate, at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pr_sel | input | 2 | Shared coarse prescale code |
| tx_pow_sel | input | 3 | Transmit power-of-two select |
| rx_pow_sel | input | 3 | Receive power-of-two select |
| tx_fine | input | 8 | Transmit fine divide (0 = bypass) |
| rx_fine | input | 8 | Receive fine divide (0 = bypass) |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_samp_tick | output | 1 | Transmit 16x oversample strobe |
| tx_bit_tick | output | 1 | Transmit bit-rate strobe |
| rx_samp_tick | output | 1 | Receive 16x oversample strobe |
| rx_bit_tick | output | 1 | Receive bit-rate strobe |

## Verification
Some properties of the tick outputs are checked by assertions on every cycle:
- the reset behaviour;
- silence of a disabled direction;
- every bit tick landing on an oversample tick;
- bit ticks being single-cycle pulses.

The other properties depend on counting cycles across whole periods, so only the directed scenarios can show them:
- the actual period lengths and the divide encodings;
- the exact first period after enable;
- the freezing of settings while enabled;
- the independence of the two directions.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int PR_SEL_W  = 2;
    localparam int POW_SEL_W = 3;
    localparam int FINE_W    = 8;
    localparam int PR_MAX    = 13;
    localparam int PR_CNT_W  = $clog2(PR_MAX + 1);
    localparam int POW_CNT_W = (1 << POW_SEL_W) - 1;

    typedef struct packed {
        logic [PR_SEL_W-1:0]  pr_sel;
        logic [POW_SEL_W-1:0] pow_sel;
        logic [FINE_W-1:0]    fine;
    } rate_cfg_t;

    // Terminal counts (divide value minus one) for each stage
    typedef struct packed {
        logic [PR_CNT_W-1:0]  pr_last;
        logic [POW_CNT_W-1:0] pow_last;
        logic [FINE_W-1:0]    fine_last;
    } div_terms_t;

    function automatic logic [PR_CNT_W-1:0] pr_terminal(input logic [PR_SEL_W-1:0] code);
        logic [PR_CNT_W-1:0] t;
        case (code)
            2'b00:   t = PR_CNT_W'(0);
            2'b01:   t = PR_CNT_W'(2);
            2'b10:   t = PR_CNT_W'(3);
            default: t = PR_CNT_W'(PR_MAX - 1);
        endcase
        return t;
    endfunction

    function automatic logic [POW_CNT_W-1:0] pow_terminal(input logic [POW_SEL_W-1:0] sel);
        logic [POW_CNT_W:0] weight;
        weight = (POW_CNT_W + 1)'(1) << sel;
        return POW_CNT_W'(weight - (POW_CNT_W + 1)'(1));
    endfunction

    function automatic logic [FINE_W-1:0] fine_terminal(input logic [FINE_W-1:0] f);
        return (f == '0) ? '0 : f - FINE_W'(1);
    endfunction

endpackage

// File: rtl/baud_cfg_hold.sv
module baud_cfg_hold
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  rate_cfg_t  cfg_i,
    output div_terms_t terms_o
);

    typedef struct packed {
        div_terms_t terms;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!en) begin
            hold_d.terms.pr_last   = pr_terminal(cfg_i.pr_sel);
            hold_d.terms.pow_last  = pow_terminal(cfg_i.pow_sel);
            hold_d.terms.fine_last = fine_terminal(cfg_i.fine);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign terms_o = hold_q.terms;

endmodule

// File: rtl/baud_div_chain.sv
module baud_div_chain
    import baud_pkg::*;
#(
    parameter int OS_RATIO = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  div_terms_t terms,
    output logic       samp_tick,
    output logic       bit_tick
);

    localparam int OS_W    = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
    localparam int OS_LAST = OS_RATIO - 1;

    typedef struct packed {
        logic [PR_CNT_W-1:0]  pr_cnt;
        logic [POW_CNT_W-1:0] pow_cnt;
        logic [FINE_W-1:0]    fine_cnt;
        logic [OS_W-1:0]      os_cnt;
        logic                 samp;
        logic                 bitp;
    } chain_t;

    chain_t ch_d, ch_q;
    logic   pr_wrap, pow_wrap, fine_wrap, os_wrap;

    always_comb begin
        ch_d      = ch_q;
        ch_d.samp = 1'b0;
        ch_d.bitp = 1'b0;
        pr_wrap   = (ch_q.pr_cnt == terms.pr_last);
        pow_wrap  = pr_wrap && (ch_q.pow_cnt == terms.pow_last);
        fine_wrap = pow_wrap && (ch_q.fine_cnt == terms.fine_last);
        os_wrap   = fine_wrap && (ch_q.os_cnt == OS_W'(OS_LAST));
        if (!en) begin
            ch_d.pr_cnt   = '0;
            ch_d.pow_cnt  = '0;
            ch_d.fine_cnt = '0;
            ch_d.os_cnt   = '0;
        end else begin
            ch_d.pr_cnt = pr_wrap ? '0 : ch_q.pr_cnt + PR_CNT_W'(1);
            if (pr_wrap) begin
                ch_d.pow_cnt = pow_wrap ? '0 : ch_q.pow_cnt + POW_CNT_W'(1);
            end
            if (pow_wrap) begin
                ch_d.fine_cnt = fine_wrap ? '0 : ch_q.fine_cnt + FINE_W'(1);
            end
            if (fine_wrap) begin
                ch_d.os_cnt = os_wrap ? '0 : ch_q.os_cnt + OS_W'(1);
            end
            ch_d.samp = fine_wrap;
            ch_d.bitp = os_wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign samp_tick = ch_q.samp;
    assign bit_tick  = ch_q.bitp;

endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
#(
    parameter int OS_RATIO = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PR_SEL_W-1:0]  pr_sel,
    input  logic [POW_SEL_W-1:0] tx_pow_sel,
    input  logic [POW_SEL_W-1:0] rx_pow_sel,
    input  logic [FINE_W-1:0]    tx_fine,
    input  logic [FINE_W-1:0]    rx_fine,
    input  logic                 tx_en,
    input  logic                 rx_en,
    output logic                 tx_samp_tick,
    output logic                 tx_bit_tick,
    output logic                 rx_samp_tick,
    output logic                 rx_bit_tick
);

    localparam int NDIR = 2;

    rate_cfg_t             cfg_in [NDIR];
    logic      [NDIR-1:0]  en_v;
    logic      [NDIR-1:0]  samp_v;
    logic      [NDIR-1:0]  bit_v;

    assign cfg_in[0] = '{pr_sel: pr_sel, pow_sel: tx_pow_sel, fine: tx_fine};
    assign cfg_in[1] = '{pr_sel: pr_sel, pow_sel: rx_pow_sel, fine: rx_fine};
    assign en_v      = {rx_en, tx_en};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        div_terms_t terms;

        baud_cfg_hold u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_v[d]),
            .cfg_i   (cfg_in[d]),
            .terms_o (terms)
        );

        baud_div_chain #(
            .OS_RATIO (OS_RATIO)
        ) u_chain (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_v[d]),
            .terms     (terms),
            .samp_tick (samp_v[d]),
            .bit_tick  (bit_v[d])
        );
    end

    assign tx_samp_tick = samp_v[0];
    assign tx_bit_tick  = bit_v[0];
    assign rx_samp_tick = samp_v[1];
    assign rx_bit_tick  = bit_v[1];

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic rx_en,
    input logic tx_samp_tick,
    input logic tx_bit_tick,
    input logic rx_samp_tick,
    input logic rx_bit_tick
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(tx_samp_tick || tx_bit_tick || rx_samp_tick || rx_bit_tick));

    // R8
    tx_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !(tx_samp_tick || tx_bit_tick));

    // R8
    rx_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !(rx_samp_tick || rx_bit_tick));

    // R6
    tx_bit_on_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_tick |-> tx_samp_tick);

    // R6
    rx_bit_on_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_tick |-> rx_samp_tick);

    // R7
    tx_bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_tick |=> !tx_bit_tick);

    // R7
    rx_bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_tick |=> !rx_bit_tick);

endmodule

bind baud_gen baud_gen_chk u_chk (.*);

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pr_sel = '0;
    logic [2:0] tx_pow_sel = '0;
    logic [2:0] rx_pow_sel = '0;
    logic [7:0] tx_fine = '0;
    logic [7:0] rx_fine = '0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       tx_samp_tick, tx_bit_tick, rx_samp_tick, rx_bit_tick;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    baud_gen u0 (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit bt(input bit rx);
        return rx ? rx_bit_tick : tx_bit_tick;
    endfunction

    function automatic bit st(input bit rx);
        return rx ? rx_samp_tick : tx_samp_tick;
    endfunction

    task automatic set_en(input bit rx, input bit v);
        if (rx) rx_en = v; else tx_en = v;
    endtask

    // Apply settings, then let one clock edge pass with enables low
    task automatic load(input logic [1:0] p, input logic [2:0] ts, input logic [7:0] tf,
                        input logic [2:0] rs, input logic [7:0] rf);
        @(negedge clk);
        pr_sel = p; tx_pow_sel = ts; tx_fine = tf; rx_pow_sel = rs; rx_fine = rf;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Enable one direction, measure first period, one full period, sample count, then disable
    task automatic measure(input bit rx, input int n, input string req);
        int c;
        int s;
        set_en(rx, 1'b1);
        c = 0;
        do begin
            @(posedge clk); c++; @(negedge clk);
        end while (!bt(rx) && c < 16 * n + 64);
        check(c == 16 * n, "R10", {req, " first bit period"}, c, 16 * n);
        c = 0; s = 0;
        do begin
            @(posedge clk); c++; @(negedge clk);
            if (st(rx)) s++;
        end while (!bt(rx) && c < 16 * n + 64);
        check(c == 16 * n, req, "bit period", c, 16 * n);
        check(s == 16, "R6", "samples per bit", s, 16);
        set_en(rx, 1'b0);
        c = 0;
        repeat (40) begin
            @(posedge clk); @(negedge clk);
            if (st(rx) || bt(rx)) c++;
        end
        check(c == 0, "R8", "ticks after disable", c, 0);
    endtask

    task automatic t_reset;
        int c = 0;
        repeat (3) begin
            @(negedge clk);
            if (tx_samp_tick || tx_bit_tick || rx_samp_tick || rx_bit_tick) c++;
        end
        check(c == 0, "R1", "ticks in reset", c, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (tx_samp_tick || tx_bit_tick || rx_samp_tick || rx_bit_tick) c++;
        end
        check(c == 0, "R8", "ticks while disabled", c, 0);
    endtask

    task automatic t_nominal;   // R2 code 2'b11 = 13, R5 fine 0 bypass
        load(2'b11, 3'd0, 8'd0, 3'd0, 8'd0);
        measure(1'b0, 13, "R2");
    endtask

    task automatic t_pow;       // R3 select 3 = 8
        load(2'b00, 3'd3, 8'd0, 3'd0, 8'd0);
        measure(1'b0, 8, "R3");
    endtask

    task automatic t_fine;      // R4 code 2'b01 = 3, sel 1, fine 5
        load(2'b01, 3'd0, 8'd0, 3'd1, 8'd5);
        measure(1'b1, 30, "R4");
        load(2'b00, 3'd0, 8'd0, 3'd0, 8'd255);
        measure(1'b1, 255, "R4");
        load(2'b00, 3'd0, 8'd0, 3'd0, 8'd1);
        measure(1'b1, 1, "R5");
        load(2'b00, 3'd0, 8'd0, 3'd0, 8'd0);
        measure(1'b1, 1, "R5");
    endtask

    task automatic t_max_pow;   // R3 select 7 = 128 with code 2'b10 = 4
        load(2'b10, 3'd7, 8'd0, 3'd0, 8'd0);
        measure(1'b0, 512, "R3");
    endtask

    task automatic t_frozen;    // R9
        int c;
        load(2'b00, 3'd0, 8'd2, 3'd0, 8'd0);
        tx_en = 1'b1;
        c = 0;
        do begin
            @(posedge clk); c++; @(negedge clk);
        end while (!tx_bit_tick && c < 200);
        pr_sel = 2'b11; tx_pow_sel = 3'd7; tx_fine = 8'd9;
        c = 0;
        do begin
            @(posedge clk); c++; @(negedge clk);
        end while (!tx_bit_tick && c < 200);
        check(c == 32, "R9", "period after change while enabled", c, 32);
        tx_en = 1'b0;
        load(2'b11, 3'd7, 8'd0, 3'd0, 8'd0);
        measure(1'b0, 1664, "R9");
    endtask

    task automatic t_both;      // R11, R7
        int ct = 0;
        int cr = 0;
        int dbl = 0;
        bit pt = 0;
        bit pr = 0;
        load(2'b00, 3'd1, 8'd0, 3'd0, 8'd3);
        tx_en = 1'b1; rx_en = 1'b1;
        repeat (960) begin
            @(posedge clk); @(negedge clk);
            if (tx_bit_tick) ct++;
            if (rx_bit_tick) cr++;
            if ((tx_bit_tick && pt) || (rx_bit_tick && pr)) dbl++;
            pt = tx_bit_tick; pr = rx_bit_tick;
        end
        check(ct == 30, "R11", "tx bit ticks in window", ct, 30);
        check(cr == 20, "R11", "rx bit ticks in window", cr, 20);
        check(dbl == 0, "R7", "back-to-back bit ticks", dbl, 0);
        tx_en = 1'b0; rx_en = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_pow();
        t_fine();
        t_max_pow();
        t_frozen();
        t_both();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule